// File: doc/BRIEF.md
# Receive Subaddress Ping-Pong Buffer Manager

This block organises where a bus remote terminal stores the data words of receive messages. Every receive subaddress owns a pair of 32-word blocks in a 4K x 16 shared RAM. One block of the pair is *active*: the local processor reads it. The other block is *inactive*: message data lands there. When a message ends, the two blocks trade roles, but only if the message was good and ping-pong operation is switched on for that subaddress. A corrupted or cut-short message therefore never disturbs the block the processor is reading.

The message decoder upstream supplies the subaddress and a broadcast flag, one strobe per data word, and an end pulse with a validity flag. The block turns each word strobe into a registered RAM write. The processor gives a subaddress and a broadcast flag and gets back, combinationally, the base address of the active block. With broadcast separation enabled, broadcast messages use a second, independent pair of blocks for each subaddress. When ping-pong is off for a subaddress, data goes straight into the active block and no swap takes place.

Top module: `rt_dbuf`

## Requirements
- R1: After reset every pair has block 0 active, so the lookup returns block bit 0 for every subaddress, and no RAM write is issued.
- R2: With ping-pong enabled for the subaddress, a word strobe produces, one clock later, a RAM write of the strobed data into the inactive block at the word's position in the message.
- R3: A message end flagged valid, for a subaddress with ping-pong enabled, swaps the active block. The lookup returns the new base from the clock edge that accepts the end.
- R4: A message end flagged invalid leaves the active block, and therefore the lookup result, unchanged.
- R5: With ping-pong disabled for the subaddress, words are written into the active block and a valid end causes no swap.
- R6: With broadcast separation on, a broadcast message uses its own pair, and the lookup with the broadcast flag set returns that pair's base. With separation off, broadcast messages and lookups use the ordinary pair.
- R7: Word strobes beyond the 32nd of a message produce no RAM write.
- R8: The word position restarts at 0 after each message end, whether valid or invalid.
- R9: A swap affects only the pair addressed by the ending message.
- R10: RAM addresses are laid out as bit 11 broadcast pair, bits 10:6 subaddress, bit 5 block, bits 4:0 word position. Lookup bases have bits 4:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbuf_en | input | 32 | Ping-pong enable, one bit per subaddress |
| bcast_sep_en | input | 1 | Route broadcast messages to a separate pair |
| ev_sa | input | 5 | Subaddress of the current message |
| ev_bcast | input | 1 | Current message is broadcast |
| ev_word | input | 1 | Data word strobe |
| ev_data | input | 16 | Data word |
| ev_end | input | 1 | Message end pulse |
| ev_valid | input | 1 | Qualifies ev_end: message was good |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 12 | RAM write address |
| ram_wdata | output | 16 | RAM write data |
| cpu_sa | input | 5 | Lookup subaddress |
| cpu_bcast | input | 1 | Lookup the broadcast pair |
| cpu_base | output | 12 | Base address of the active block |

## Verification
The assertions take for granted that ev_sa, ev_bcast, bcast_sep_en and the addressed dbuf_en bit stay constant from the first word of a message through its end pulse. They also assume that the configuration does not change while a lookup is being compared across cycles. The stimulus sets the configuration only between messages and holds the subaddress and broadcast flag for the whole of each message. It sweeps every subaddress, both broadcast settings and both separation settings. Ping-pong enables follow a fixed pattern with mixed bits, and the stimulus includes valid, invalid and over-long messages.

// File: rtl/rt_dbuf_pkg.sv
package rt_dbuf_pkg;
    localparam int SA_W_DEF  = 5;   // subaddress width
    localparam int IDX_W_DEF = 5;   // log2 of words per block
    localparam int DW_DEF    = 16;  // RAM word width
endpackage

// File: rtl/rt_dbuf_addr.sv
module rt_dbuf_addr #(
    parameter int SA_W  = rt_dbuf_pkg::SA_W_DEF,
    parameter int IDX_W = rt_dbuf_pkg::IDX_W_DEF,
    localparam int AW   = 2 + SA_W + IDX_W
) (
    input  logic            bc,
    input  logic [SA_W-1:0] sa,
    input  logic            blk,
    output logic [AW-1:0]   base
);
    assign base = {bc, sa, blk, {IDX_W{1'b0}}};
endmodule

// File: rtl/rt_dbuf_ctrl.sv
module rt_dbuf_ctrl #(
    parameter int SA_W  = rt_dbuf_pkg::SA_W_DEF,
    parameter int IDX_W = rt_dbuf_pkg::IDX_W_DEF,
    parameter int DW    = rt_dbuf_pkg::DW_DEF,
    localparam int NSA   = 1 << SA_W,
    localparam int NPAIR = 2 * NSA,
    localparam int AW    = 2 + SA_W + IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSA-1:0]   dbuf_en,
    input  logic             bcast_sep_en,
    input  logic [SA_W-1:0]  ev_sa,
    input  logic             ev_bcast,
    input  logic             ev_word,
    input  logic [DW-1:0]    ev_data,
    input  logic             ev_end,
    input  logic             ev_valid,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [DW-1:0]    ram_wdata,
    output logic [NPAIR-1:0] act
);
    typedef struct packed {
        logic [NPAIR-1:0] act;
        logic [IDX_W:0]   cnt;
        logic             we;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
    } st_t;

    st_t st_d, st_q;

    logic               wr_bc;
    logic [SA_W:0]      wr_pair;
    logic               cur_act;
    logic               wr_blk;
    logic [AW-1:0]      wr_base;

    assign wr_bc   = ev_bcast & bcast_sep_en;
    assign wr_pair = {wr_bc, ev_sa};
    assign cur_act = st_q.act[wr_pair];
    assign wr_blk  = dbuf_en[ev_sa] ? ~cur_act : cur_act;

    rt_dbuf_addr #(.SA_W(SA_W), .IDX_W(IDX_W)) u_wr_addr (
        .bc   (wr_bc),
        .sa   (ev_sa),
        .blk  (wr_blk),
        .base (wr_base)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (ev_word && !st_q.cnt[IDX_W]) begin
            st_d.we   = 1'b1;
            st_d.addr = wr_base | AW'(st_q.cnt[IDX_W-1:0]);
            st_d.data = ev_data;
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        if (ev_end) begin
            st_d.cnt = '0;
            if (ev_valid && dbuf_en[ev_sa]) begin
                st_d.act[wr_pair] = ~cur_act;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_we    = st_q.we;
    assign ram_addr  = st_q.addr;
    assign ram_wdata = st_q.data;
    assign act       = st_q.act;
endmodule

// File: rtl/rt_dbuf.sv
module rt_dbuf #(
    parameter int SA_W  = rt_dbuf_pkg::SA_W_DEF,
    parameter int IDX_W = rt_dbuf_pkg::IDX_W_DEF,
    parameter int DW    = rt_dbuf_pkg::DW_DEF,
    localparam int NSA   = 1 << SA_W,
    localparam int NPAIR = 2 * NSA,
    localparam int AW    = 2 + SA_W + IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSA-1:0]  dbuf_en,
    input  logic            bcast_sep_en,
    input  logic [SA_W-1:0] ev_sa,
    input  logic            ev_bcast,
    input  logic            ev_word,
    input  logic [DW-1:0]   ev_data,
    input  logic            ev_end,
    input  logic            ev_valid,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_wdata,
    input  logic [SA_W-1:0] cpu_sa,
    input  logic            cpu_bcast,
    output logic [AW-1:0]   cpu_base
);
    logic [NPAIR-1:0] act;
    logic             rd_bc;

    rt_dbuf_ctrl #(.SA_W(SA_W), .IDX_W(IDX_W), .DW(DW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .dbuf_en      (dbuf_en),
        .bcast_sep_en (bcast_sep_en),
        .ev_sa        (ev_sa),
        .ev_bcast     (ev_bcast),
        .ev_word      (ev_word),
        .ev_data      (ev_data),
        .ev_end       (ev_end),
        .ev_valid     (ev_valid),
        .ram_we       (ram_we),
        .ram_addr     (ram_addr),
        .ram_wdata    (ram_wdata),
        .act          (act)
    );

    assign rd_bc = cpu_bcast & bcast_sep_en;

    rt_dbuf_addr #(.SA_W(SA_W), .IDX_W(IDX_W)) u_rd_addr (
        .bc   (rd_bc),
        .sa   (cpu_sa),
        .blk  (act[{rd_bc, cpu_sa}]),
        .base (cpu_base)
    );
endmodule

// File: rtl/rt_dbuf_chk.sv
module rt_dbuf_chk #(
    parameter int SA_W  = rt_dbuf_pkg::SA_W_DEF,
    parameter int IDX_W = rt_dbuf_pkg::IDX_W_DEF,
    parameter int DW    = rt_dbuf_pkg::DW_DEF,
    localparam int AW   = 2 + SA_W + IDX_W
) (
    input logic            clk,
    input logic            rst,
    input logic            bcast_sep_en,
    input logic            ev_word,
    input logic [DW-1:0]   ev_data,
    input logic            ev_end,
    input logic            ev_valid,
    input logic            ram_we,
    input logic [AW-1:0]   ram_addr,
    input logic [DW-1:0]   ram_wdata,
    input logic [SA_W-1:0] cpu_sa,
    input logic            cpu_bcast,
    input logic [AW-1:0]   cpu_base
);
    localparam int NW = 1 << IDX_W;

    int unsigned seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 0;
        end else if (ev_end) begin
            seen_q <= 0;
        end else if (ev_word && seen_q < NW) begin
            seen_q <= seen_q + 1;
        end
    end

    // R2
    word_write_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_word && seen_q < NW) |=> (ram_we && ram_wdata == $past(ev_data)
            && ram_addr[IDX_W-1:0] == IDX_W'($past(seen_q))));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_word && seen_q >= NW) |=> !ram_we);

    // R4
    hold_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        !(ev_end && ev_valid) |=> (!$stable(cpu_sa) || !$stable(cpu_bcast)
            || !$stable(bcast_sep_en) || $stable(cpu_base)));

    // R10
    base_layout_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_base[IDX_W-1:0] == '0 && cpu_base[AW-2 -: SA_W] == cpu_sa);

    // R2
    idle_write_chk: assert property (@(posedge clk) disable iff (rst)
        !ev_word |=> !ram_we);
endmodule

bind rt_dbuf rt_dbuf_chk #(.SA_W(SA_W), .IDX_W(IDX_W), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bcast_sep_en (bcast_sep_en),
    .ev_word      (ev_word),
    .ev_data      (ev_data),
    .ev_end       (ev_end),
    .ev_valid     (ev_valid),
    .ram_we       (ram_we),
    .ram_addr     (ram_addr),
    .ram_wdata    (ram_wdata),
    .cpu_sa       (cpu_sa),
    .cpu_bcast    (cpu_bcast),
    .cpu_base     (cpu_base)
);

// File: tb/sim_rt_dbuf.sv
`timescale 1ns/1ps
module sim_rt_dbuf;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] dbuf_en;
    logic        bcast_sep_en;
    logic [4:0]  ev_sa;
    logic        ev_bcast, ev_word, ev_end, ev_valid;
    logic [15:0] ev_data;
    logic        ram_we;
    logic [11:0] ram_addr;
    logic [15:0] ram_wdata;
    logic [4:0]  cpu_sa;
    logic        cpu_bcast;
    logic [11:0] cpu_base;

    int checks = 0;
    int errors = 0;
    bit exp_act [64];

    always #2.5 clk = ~clk;

    rt_dbuf u0 (
        .clk(clk), .rst(rst), .dbuf_en(dbuf_en), .bcast_sep_en(bcast_sep_en),
        .ev_sa(ev_sa), .ev_bcast(ev_bcast), .ev_word(ev_word), .ev_data(ev_data),
        .ev_end(ev_end), .ev_valid(ev_valid), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cpu_sa(cpu_sa), .cpu_bcast(cpu_bcast), .cpu_base(cpu_base)
    );

    function automatic bit dben(int sa);
        return bit'(sa[0] ^ sa[3]);
    endfunction

    function automatic int pair_of(int sa, int bc);
        return ((bc != 0 && bcast_sep_en) ? 32 : 0) + sa;
    endfunction

    function automatic logic [11:0] exp_base(int sa, int bc);
        int p = pair_of(sa, bc);
        return {1'(p / 32), 5'(sa), exp_act[p], 5'b0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic lookup(int sa, int bc, string req);
        cpu_sa = 5'(sa);
        cpu_bcast = 1'(bc);
        #0.5;
        check(req, 32'(cpu_base), 32'(exp_base(sa, bc)), "lookup base");
    endtask

    task automatic run_msg(int sa, int bc, int n, bit valid, string req);
        int p = pair_of(sa, bc);
        bit blk = dben(sa) ? !exp_act[p] : exp_act[p];
        ev_sa = 5'(sa);
        ev_bcast = 1'(bc);
        for (int i = 0; i < n; i++) begin
            logic [15:0] d = 16'(sa * 977 + i * 13 + bc * 4001);
            ev_word = 1'b1;
            ev_data = d;
            @(negedge clk);
            if (i < 32) begin
                check(req, {ram_we, ram_wdata, 3'b0, ram_addr},
                      {1'b1, d, 3'b0, 1'(p / 32), 5'(sa), blk, 5'(i)}, "word write");
            end else begin
                check("R7", 32'(ram_we), 32'd0, "overflow word write enable");
            end
        end
        ev_word = 1'b0;
        ev_end = 1'b1;
        ev_valid = valid;
        @(negedge clk);
        ev_end = 1'b0;
        ev_valid = 1'b0;
        if (valid && dben(sa)) exp_act[p] = !exp_act[p];
        check(req, 32'(ram_we), 32'd0, "no write on end cycle");
        lookup(sa, bc, valid ? (dben(sa) ? "R3" : "R5") : "R4");
        lookup(sa ^ 1, bc, "R9");
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        for (int s = 0; s < 32; s++) dbuf_en[s] = dben(s);
        bcast_sep_en = 1'b1;
        ev_sa = '0; ev_bcast = 0; ev_word = 0; ev_data = '0; ev_end = 0; ev_valid = 0;
        cpu_sa = '0; cpu_bcast = 0;
        for (int p = 0; p < 64; p++) exp_act[p] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 32'(ram_we), 32'd0, "write enable after reset");
        for (int s = 0; s < 32; s++)
            for (int b = 0; b < 2; b++) lookup(s, b, "R1");

        // separation on: both pairs per subaddress, valid then invalid
        for (int s = 0; s < 32; s++) begin
            for (int b = 0; b < 2; b++) begin
                run_msg(s, b, 3 + s % 4, 1'b1, dben(s) ? "R2" : "R5");
                run_msg(s, b, 2, 1'b0, b != 0 ? "R6" : "R8");
            end
        end

        // over-long message, then index restart
        run_msg(7, 0, 34, 1'b1, "R2");
        run_msg(7, 0, 2, 1'b1, "R8");
        run_msg(9, 1, 33, 1'b0, "R6");
        run_msg(9, 1, 1, 1'b1, "R8");

        // separation off: broadcast uses ordinary pair
        bcast_sep_en = 1'b0;
        for (int s = 0; s < 32; s += 3) begin
            run_msg(s, 1, 2, 1'b1, "R6");
            lookup(s, 0, "R6");
        end
        bcast_sep_en = 1'b1;

        // full sweep of all pairs against model
        for (int s = 0; s < 32; s++)
            for (int b = 0; b < 2; b++) lookup(s, b, "R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule